// File: doc/BRIEF.md
# Escaped-Delimiter Frame Decoder

This block sits behind a byte receiver and recovers frame payloads from a stream in which frames are bounded by a delimiter byte (0x02) and any payload byte equal to the delimiter or to the escape byte (0x10) is sent with an escape byte in front of it. Raw bytes come in on a valid/ready stream. Payload bytes go out on a second valid/ready stream, and a one-cycle end-of-frame pulse marks each completed frame. Bytes that arrive outside a frame are thrown away.

Three pieces of state drive every decision: an escape-pending flag, an in-frame flag and a payload length counter for the current frame. The counter saturates at its maximum rather than wrapping. A delimiter that arrives while the frame still has zero payload bytes is not taken as an empty frame. It is taken as a fresh start, so a receiver that lost sync recovers on a repeated delimiter. The decode is combinational from input to output, one byte per cycle. A dropped byte is always accepted at once, and a payload byte is accepted only when the output side is ready.

Top module: `stuffed_frame_rx`

## Requirements
- R1: After a synchronous reset the block is outside a frame with no escape pending: an ordinary byte is dropped (out_valid low, out_eof low, in_ready high).
- R2: Any byte other than 0x02 and 0x10 arriving outside a frame is dropped and accepted in the same cycle, even while out_ready is low.
- R3: A delimiter 0x02 with no escape pending, outside a frame, is dropped and opens a frame. Later ordinary bytes leave on out_data unchanged and in arrival order, with out_valid high.
- R4: An escape 0x10 with no escape pending is dropped and sets escape pending. A following 0x02 or 0x10 inside a frame is output as payload and clears escape pending.
- R5: A delimiter 0x02 with no escape pending, inside a frame holding at least one payload byte, is dropped. It raises out_eof in the cycle it is accepted, with out_valid low and in_ready high, and closes the frame, so the bytes after it are dropped.
- R6: A delimiter 0x02 with no escape pending, inside a frame holding zero payload bytes, is dropped without out_eof, and the block stays inside the frame.
- R7: A delimiter 0x02 with escape pending, outside a frame, is dropped and clears escape pending.
- R8: An escape 0x10 with escape pending, outside a frame, is dropped and leaves escape pending set.
- R9: An ordinary byte inside a frame is output as payload whether or not an escape is pending, and it leaves the escape-pending flag unchanged.
- R10: While a payload byte is presented and out_ready is low, in_ready is low, out_valid stays high and no state changes.
- R11: The payload length counter saturates at 255, so a frame of 256 or more payload bytes is still closed by 0x02 with out_eof.
- R12: A synchronous reset in the middle of a frame clears escape pending, the in-frame flag and the length counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Received byte accepted this cycle |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Consumer takes the payload byte |
| out_data | output | 8 | Payload byte |
| out_eof | output | 1 | One-cycle pulse when a closing delimiter is accepted |

## Verification
A wrong escape-pending flag stays hidden until the next 0x02 or 0x10 arrives. That byte is then passed out when it should be dropped, or the reverse, in the same cycle, and the sequences in the bench are built so that each flag value decides whether that byte appears. A wrong in-frame flag shows on the very next ordinary byte as a missing or spurious out_valid. A wrong length counter shows only when a delimiter arrives: out_eof is missing after a non-empty frame (a counter that wraps at exactly 256 bytes), or it appears right after a resynchronising start. Stalls are checked by holding out_ready low and then confirming that the next delimiter still closes the frame.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [1:0] {
      SFR_DROP  = 2'd0,
      SFR_PASS  = 2'd1,
      SFR_CLOSE = 2'd2
   } sfr_act_e;

endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
   import sfr_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter logic [7:0]  DELIM  = 8'h02,
   parameter logic [7:0]  ESC    = 8'h10
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic              esc_q,
   input  logic              frame_q,
   input  logic              len_zero,
   output sfr_act_e          act,
   output logic              esc_n,
   output logic              frame_n
);

   logic is_delim;
   logic is_esc;

   assign is_delim = (byte_i == DATA_W'(DELIM));
   assign is_esc   = (byte_i == DATA_W'(ESC));

   always_comb begin
      act     = SFR_DROP;
      esc_n   = esc_q;
      frame_n = frame_q;
      if (is_esc) begin
         if (!esc_q) begin
            esc_n = 1'b1;
         end else if (frame_q) begin
            act   = SFR_PASS;
            esc_n = 1'b0;
         end
      end else if (is_delim) begin
         if (!esc_q) begin
            if (!frame_q) begin
               frame_n = 1'b1;
            end else if (!len_zero) begin
               act     = SFR_CLOSE;
               frame_n = 1'b0;
            end
         end else begin
            esc_n = 1'b0;
            if (frame_q) begin
               act = SFR_PASS;
            end
         end
      end else if (frame_q) begin
         act = SFR_PASS;
      end
   end

endmodule

// File: rtl/sfr_flags.sv
module sfr_flags (
   input  logic clk,
   input  logic rst,
   input  logic consume,
   input  logic esc_n,
   input  logic frame_n,
   output logic esc_q,
   output logic frame_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         esc_q   <= 1'b0;
         frame_q <= 1'b0;
      end else if (consume) begin
         esc_q   <= esc_n;
         frame_q <= frame_n;
      end
   end

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !consume |=> $stable({esc_q, frame_q}));

   p_reset_clears_r12: assert property (@(posedge clk)
      rst |=> (!esc_q && !frame_q));

endmodule

// File: rtl/sfr_len_ctr.sv
module sfr_len_ctr #(
   parameter int LEN_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic inc,
   input  logic clr,
   output logic len_zero
);

   localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

   logic [LEN_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (inc && (cnt != LEN_MAX)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign len_zero = (cnt == '0);

   p_saturate_r11: assert property (@(posedge clk) disable iff (rst)
      (cnt == LEN_MAX && !clr) |=> (cnt == LEN_MAX));

   p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      clr |=> len_zero);

endmodule

// File: rtl/stuffed_frame_rx.sv
module stuffed_frame_rx
   import sfr_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter int          LEN_W  = 8,
   parameter logic [7:0]  DELIM  = 8'h02,
   parameter logic [7:0]  ESC    = 8'h10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_eof
);

   initial begin
      assert (DATA_W >= 5 && DATA_W <= 8) else $error("DATA_W must hold both control codes");
      assert (LEN_W >= 1) else $error("LEN_W must be at least 1");
      assert (DELIM != ESC) else $error("delimiter and escape must differ");
   end

   sfr_act_e act;
   logic     esc_q, frame_q, esc_n, frame_n, len_zero, consume;

   sfr_decode #(.DATA_W(DATA_W), .DELIM(DELIM), .ESC(ESC)) u_dec (
      .byte_i   (in_data),
      .esc_q    (esc_q),
      .frame_q  (frame_q),
      .len_zero (len_zero),
      .act      (act),
      .esc_n    (esc_n),
      .frame_n  (frame_n)
   );

   assign in_ready  = (act == SFR_PASS) ? out_ready : 1'b1;
   assign consume   = in_valid && in_ready;
   assign out_valid = in_valid && (act == SFR_PASS);
   assign out_data  = in_data;
   assign out_eof   = in_valid && (act == SFR_CLOSE);

   sfr_flags u_flags (
      .clk     (clk),
      .rst     (rst),
      .consume (consume),
      .esc_n   (esc_n),
      .frame_n (frame_n),
      .esc_q   (esc_q),
      .frame_q (frame_q)
   );

   sfr_len_ctr #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst      (rst),
      .inc      (consume && (act == SFR_PASS)),
      .clr      (consume && (act == SFR_CLOSE)),
      .len_zero (len_zero)
   );

   p_payload_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> frame_q);

   p_eof_alone_r5: assert property (@(posedge clk) disable iff (rst)
      out_eof |-> (!out_valid && in_ready && !len_zero));

   p_eof_closes_r5: assert property (@(posedge clk) disable iff (rst)
      out_eof |=> (!frame_q && len_zero && !out_eof));

   p_drop_no_stall_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !out_valid) |-> in_ready);

   p_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/sim_stuffed_frame_rx.sv
module sim_stuffed_frame_rx;

   localparam logic [7:0] DL = 8'h02;
   localparam logic [7:0] EC = 8'h10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;
   logic       out_eof;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   stuffed_frame_rx u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_eof(out_eof)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Present one byte with out_ready high, check the combinational result, let it be accepted.
   task automatic put(input logic [7:0] b, input logic exp_v, input logic exp_eof, input string req);
      @(negedge clk);
      out_ready = 1'b1;
      in_valid = 1'b1;
      in_data = b;
      #1;
      chk(req, "out_valid", out_valid, exp_v);
      chk(req, "out_eof", out_eof, exp_eof);
      chk(req, "in_ready", in_ready, 1'b1);
      if (exp_v) chk(req, "out_data", out_data, b);
      @(posedge clk);
   endtask

   task automatic t_reset_r1();
      do_reset();
      put(8'h41, 1'b0, 1'b0, "R1");
      put(8'h42, 1'b0, 1'b0, "R1");
   endtask

   task automatic t_outside_r2();
      do_reset();
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1;
      in_data = 8'h7f;
      #1;
      chk("R2", "in_ready with out_ready low", in_ready, 1'b1);
      chk("R2", "out_valid", out_valid, 1'b0);
      @(posedge clk);
      put(8'hff, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_basic_r3_r5();
      do_reset();
      put(DL,    1'b0, 1'b0, "R3");
      put(8'h41, 1'b1, 1'b0, "R3");
      put(8'h42, 1'b1, 1'b0, "R3");
      put(DL,    1'b0, 1'b1, "R5");
      put(8'h43, 1'b0, 1'b0, "R5");
   endtask

   task automatic t_escape_r4();
      do_reset();
      put(DL,    1'b0, 1'b0, "R4");
      put(EC,    1'b0, 1'b0, "R4");
      put(DL,    1'b1, 1'b0, "R4");
      put(EC,    1'b0, 1'b0, "R4");
      put(EC,    1'b1, 1'b0, "R4");
      put(8'h33, 1'b1, 1'b0, "R4");
      put(DL,    1'b0, 1'b1, "R4");
   endtask

   task automatic t_resync_r6();
      do_reset();
      put(DL,    1'b0, 1'b0, "R6");
      put(DL,    1'b0, 1'b0, "R6");
      put(DL,    1'b0, 1'b0, "R6");
      put(8'h44, 1'b1, 1'b0, "R6");
      put(DL,    1'b0, 1'b1, "R6");
   endtask

   task automatic t_esc_delim_outside_r7();
      do_reset();
      put(EC,    1'b0, 1'b0, "R7");
      put(DL,    1'b0, 1'b0, "R7");
      put(8'h45, 1'b0, 1'b0, "R7");
      put(DL,    1'b0, 1'b0, "R7");
      put(8'h46, 1'b1, 1'b0, "R7");
      put(DL,    1'b0, 1'b1, "R7");
   endtask

   task automatic t_esc_esc_outside_r8();
      do_reset();
      put(EC,    1'b0, 1'b0, "R8");
      put(EC,    1'b0, 1'b0, "R8");
      put(DL,    1'b0, 1'b0, "R8");
      put(8'h47, 1'b0, 1'b0, "R8");
      put(DL,    1'b0, 1'b0, "R8");
      put(8'h48, 1'b1, 1'b0, "R8");
      put(DL,    1'b0, 1'b1, "R8");
   endtask

   task automatic t_pending_plain_r9();
      do_reset();
      put(DL,    1'b0, 1'b0, "R9");
      put(8'h41, 1'b1, 1'b0, "R9");
      put(EC,    1'b0, 1'b0, "R9");
      put(8'h42, 1'b1, 1'b0, "R9");
      put(DL,    1'b1, 1'b0, "R9");
      put(8'h43, 1'b1, 1'b0, "R9");
      put(DL,    1'b0, 1'b1, "R9");
   endtask

   task automatic t_stall_r10();
      do_reset();
      put(DL, 1'b0, 1'b0, "R10");
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1;
      in_data = 8'h5a;
      for (int i = 0; i < 3; i++) begin
         #1;
         chk("R10", "in_ready stalled", in_ready, 1'b0);
         chk("R10", "out_valid held", out_valid, 1'b1);
         @(negedge clk);
      end
      out_ready = 1'b1;
      #1;
      chk("R10", "in_ready released", in_ready, 1'b1);
      chk("R10", "out_data", out_data, 8'h5a);
      @(posedge clk);
      put(DL,    1'b0, 1'b1, "R10");
      put(8'h11, 1'b0, 1'b0, "R10");
   endtask

   task automatic t_saturate_r11();
      do_reset();
      put(DL, 1'b0, 1'b0, "R11");
      for (int i = 0; i < 256; i++) put(8'h55, 1'b1, 1'b0, "R11");
      put(DL, 1'b0, 1'b1, "R11");
   endtask

   task automatic t_midreset_r12();
      do_reset();
      put(DL,    1'b0, 1'b0, "R12");
      put(8'h41, 1'b1, 1'b0, "R12");
      put(EC,    1'b0, 1'b0, "R12");
      do_reset();
      put(8'h42, 1'b0, 1'b0, "R12");
      put(DL,    1'b0, 1'b0, "R12");
      put(DL,    1'b0, 1'b0, "R12");
      put(8'h44, 1'b1, 1'b0, "R12");
      put(DL,    1'b0, 1'b1, "R12");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_r1();
      t_outside_r2();
      t_basic_r3_r5();
      t_escape_r4();
      t_resync_r6();
      t_esc_delim_outside_r7();
      t_esc_esc_outside_r8();
      t_pending_plain_r9();
      t_stall_r10();
      t_saturate_r11();
      t_midreset_r12();
      @(negedge clk);
      in_valid = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule